// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets software talk to an Ethernet PHY's management registers over the two-wire MDIO bus. Software packs a whole clause-22 management transaction into a single 32-bit maintenance word and writes it. If the management port is enabled and idle, the controller then shifts the frame out on MDC/MDIO. The frame is a 32-bit preamble of ones followed by the maintenance word, most significant bit first.

For a read, the controller releases the data line for the turnaround and data phases. It samples the sixteen bits the PHY returns and writes them into the low half of the maintenance word. Software tracks completion by polling an idle flag in a status register.

MDC is produced from the bus clock by a divisor selected in a configuration field. The output enable for the external tri-state pad is provided, but the pad itself lives outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold: the enable bit is 0, the divisor field is 0, the maintenance word is 0, the status idle bit (status bit 2) reads 1, MDC is low and the MDIO output enable is low.
- R2: The registers sit at word addresses 0 (control), 1 (configuration), 2 (status) and 3 (maintenance word). Control bit 4 is the port enable and configuration bits 20:18 are the divisor select. Every other bit of those two registers reads back 0.
- R3: A write to the maintenance word while the port is enabled and idle starts a frame. The idle bit reads 0 from the next cycle and returns to 1 exactly 64 x D cycles after the write edge, where D is the selected divisor.
- R4: The frame on MDIO is 32 ones followed by maintenance bits 31 down to 0. Each bit changes only on a falling MDC edge and holds across the rising edge. For a write operation (bits 29:28 = 01), the output enable stays high for all 64 bits.
- R5: The divisor select gives D = 8, 16, 32, 48, 64, 96, 128, 224 for values 0 to 7. The MDC period is D bus clocks with D/2 of them high, and MDC stays low whenever the port is idle.
- R6: For a read operation (bits 29:28 = 10), the output enable is low for frame bits 46 to 63 (turnaround and data). The sixteen data bits are sampled on rising MDC edges, most significant bit first.
- R7: When a read frame ends, maintenance bits 15:0 take the sampled data in the same cycle that idle returns to 1, and bits 31:16 are kept. A write frame leaves the maintenance word unchanged.
- R8: With the enable bit clear, a write to the maintenance word stores the value but emits nothing: MDC stays low, the output enable stays low and idle stays 1.
- R9: A write to the maintenance word while a frame is in progress is ignored. The register reads back the word of the frame in progress, and that frame completes unaltered.
- R10: The MDIO output enable is low whenever the port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad driver |
| mdio_i | input | 1 | Management data returned from the pad |

## Verification
The hardest situation to reach is a second maintenance write that lands in the middle of a frame. It has to hit while the shifter is many bits into the preamble, and the data has to be observed both in the register readback and on the wire. The bench starts a frame, waits a fixed number of cycles, issues the conflicting write, and then compares all 64 captured MDIO bits against the original word. Read data return is exercised by a responder that drives the turnaround zero and a chosen data word, with its bit index counted from observed MDC rising edges. This checks that the sampled value replaces only the low half of the word.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants, register addresses, operation codes and the
// divisor lookup for the MDIO management controller.
// Assumes clause-22 frames of 32 preamble bits plus a 32-bit word.
package mdio_mgmt_pkg;

    localparam int WORD_W        = 32;
    localparam int PREAMBLE_BITS = 32;
    localparam int FRAME_BITS    = PREAMBLE_BITS + WORD_W;
    localparam int IDX_W         = $clog2(FRAME_BITS);
    localparam int RD_DATA_W     = 16;
    // Frame bit index where a read releases the line (turnaround start)
    localparam int RD_RELEASE_BIT = FRAME_BITS - RD_DATA_W - 2;
    // Frame bit index of the first returned data bit
    localparam int RD_DATA_BIT    = FRAME_BITS - RD_DATA_W;

    // Register word addresses
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_CFG    = 1;
    localparam int ADDR_STATUS = 2;
    localparam int ADDR_MAINT  = 3;

    // Bit positions used by neighbouring software
    localparam int CTRL_EN_BIT   = 4;
    localparam int CFG_DIV_LSB   = 18;
    localparam int STAT_IDLE_BIT = 2;
    localparam int OP_MSB        = 29;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    // Map the 3-bit divisor select onto a bus-clock divide ratio
    function automatic int unsigned div_from_sel(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 32;
            3'd3:    return 48;
            3'd4:    return 64;
            3'd5:    return 96;
            3'd6:    return 128;
            default: return 224;
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: while run_i is high, divides the bus clock by the
// selected ratio. MDC is low for the first half of each period and
// high for the second. Emits one-cycle rise/fall ticks that coincide
// with the edges on which MDC goes high/low.
// Assumes the ratio is even and fits in CNT_W bits.
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] div_sel_i,
    output logic       mdc_o,
    output logic       rise_o,
    output logic       fall_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_m1;
    logic [CNT_W-1:0] half_m1;
    logic             mdc_q;

    // Derive terminal counts from the selected ratio
    always_comb begin
        div_m1  = CNT_W'(div_from_sel(div_sel_i) - 1);
        half_m1 = CNT_W'((div_from_sel(div_sel_i) >> 1) - 1);
    end

    assign rise_o = run_i && (cnt_q == half_m1);
    assign fall_o = run_i && (cnt_q >= div_m1);
    assign mdc_o  = mdc_q;

    // Phase counter and MDC level
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (fall_o) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rise_o) begin
                mdc_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_frame_shift.sv
// Frame shifter: on start_i loads preamble plus maintenance word and
// shifts it out MSB first, advancing on each MDC fall tick. For read
// frames it releases the line from the turnaround onward and collects
// the returned data on rise ticks. Reports busy and a one-cycle done.
// Assumes rise and fall ticks never occur in the same cycle.
module mdio_frame_shift
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [WORD_W-1:0]    word_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 mdio_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    output logic [RD_DATA_W-1:0] rx_data_o
);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  is_read_q;
    logic [RD_DATA_W-1:0]  rx_q;
    logic                  last_bit;

    assign last_bit  = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign done_o    = busy_q && fall_i && last_bit;
    assign busy_o    = busy_q;
    assign mdio_o    = busy_q ? shreg_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe_o = busy_q && !(is_read_q && (idx_q >= IDX_W'(RD_RELEASE_BIT)));
    assign rx_data_o = rx_q;

    // Load, shift and sample sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            idx_q     <= '0;
            busy_q    <= 1'b0;
            is_read_q <= 1'b0;
            rx_q      <= '0;
        end else if (start_i) begin
            shreg_q   <= {{PREAMBLE_BITS{1'b1}}, word_i};
            idx_q     <= '0;
            busy_q    <= 1'b1;
            is_read_q <= (word_i[OP_MSB -: 2] == OP_READ);
        end else if (busy_q) begin
            if (fall_i) begin
                if (last_bit) begin
                    busy_q <= 1'b0;
                end else begin
                    shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                    idx_q   <= idx_q + 1'b1;
                end
            end
            if (rise_i && is_read_q && (idx_q >= IDX_W'(RD_DATA_BIT))) begin
                rx_q <= {rx_q[RD_DATA_W-2:0], mdio_i};
            end
        end
    end

    // R4: the driven bit holds except at a fall tick
    a_r4_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fall_i) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_mgmt_regs.sv
// Register file: control (enable), configuration (divisor select),
// status (idle) and the maintenance word. Decides when a maintenance
// write launches a frame, blocks writes to the word mid-frame, and
// merges returned read data when a read frame finishes.
// Assumes done_i is a single-cycle pulse while busy_i is still high.
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [WORD_W-1:0]    rdata_o,
    input  logic                 busy_i,
    input  logic                 done_i,
    input  logic [RD_DATA_W-1:0] rx_data_i,
    output logic                 start_o,
    output logic [2:0]           div_sel_o
);

    logic              en_q;
    logic [2:0]        div_sel_q;
    logic [WORD_W-1:0] maint_q;
    logic              maint_wr;

    assign maint_wr  = wr_en_i && (addr_i == ADDR_W'(ADDR_MAINT)) && !busy_i;
    assign start_o   = maint_wr && en_q;
    assign div_sel_o = div_sel_q;

    // Register updates from the bus and from frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            div_sel_q <= '0;
            maint_q   <= '0;
        end else begin
            if (wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL))) begin
                en_q <= wdata_i[CTRL_EN_BIT];
            end
            if (wr_en_i && (addr_i == ADDR_W'(ADDR_CFG))) begin
                div_sel_q <= wdata_i[CFG_DIV_LSB +: 3];
            end
            if (maint_wr) begin
                maint_q <= wdata_i;
            end else if (done_i && (maint_q[OP_MSB -: 2] == OP_READ)) begin
                maint_q[RD_DATA_W-1:0] <= rx_data_i;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_CTRL):   rdata_o[CTRL_EN_BIT] = en_q;
            ADDR_W'(ADDR_CFG):    rdata_o[CFG_DIV_LSB +: 3] = div_sel_q;
            ADDR_W'(ADDR_STATUS): rdata_o[STAT_IDLE_BIT] = !busy_i;
            default:              rdata_o = maint_q;
        endcase
    end

    // R9: the word is frozen while a frame runs, up to its last cycle
    a_r9_word_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(maint_q));

    // R7: a finished write frame leaves the word as it was
    a_r7_write_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (maint_q[OP_MSB -: 2] == OP_WRITE)) |=> $stable(maint_q));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top: MDIO management frame controller. Joins the register file,
// MDC generator and frame shifter. The MDC generator runs only while
// a frame is in progress. The pad tri-state is external, driven from
// mdio_o / mdio_oe_o.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);

    logic                 start;
    logic                 busy;
    logic                 done;
    logic                 rise_tick;
    logic                 fall_tick;
    logic [2:0]           div_sel;
    logic [RD_DATA_W-1:0] rx_data;

    mdio_mgmt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_i    (busy),
        .done_i    (done),
        .rx_data_i (rx_data),
        .start_o   (start),
        .div_sel_o (div_sel)
    );

    mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .div_sel_i (div_sel),
        .mdc_o     (mdc_o),
        .rise_o    (rise_tick),
        .fall_o    (fall_tick)
    );

    mdio_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .word_i    (reg_wdata),
        .rise_i    (rise_tick),
        .fall_i    (fall_tick),
        .mdio_i    (mdio_i),
        .busy_o    (busy),
        .done_o    (done),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .rx_data_o (rx_data)
    );

    // R3: an accepted launch makes the port busy on the next cycle
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R5: MDC rests low whenever no frame is running
    a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc_o);

    // R10: the pad is not driven while idle
    a_r10_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe_o);

endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
// Bench: table-driven frames at the fastest divisor, then directed
// tests for reset, register fields, slow divisors, mid-frame writes
// and the disabled port. A responder model answers read frames.
module mdio_mgmt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    wire  [31:0] reg_rdata;
    wire         mdc;
    wire         mdo;
    wire         mdoe;
    logic        mdi;

    mdio_mgmt_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc_o     (mdc),
        .mdio_o    (mdo),
        .mdio_oe_o (mdoe),
        .mdio_i    (mdi)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Wire monitor: records each bit at the rising MDC edge
    logic        mdc_prev = 1'b0;
    bit          mon_clr = 1'b0;
    int          mon_cnt = 0;
    int          hi_cnt = 0;
    logic        cap_o [64];
    logic        cap_oe[64];
    int unsigned rise_cyc[64];
    logic [15:0] rsp = 16'h0;

    always @(negedge clk) begin
        mdc_prev <= mdc;
        if (mon_clr) begin
            mon_cnt <= 0;
            hi_cnt  <= 0;
        end else begin
            if (mdc) hi_cnt <= hi_cnt + 1;
            if (mdc && !mdc_prev && mon_cnt < 64) begin
                cap_o[mon_cnt]    <= mdo;
                cap_oe[mon_cnt]   <= mdoe;
                rise_cyc[mon_cnt] <= cyc;
                mon_cnt           <= mon_cnt + 1;
            end
        end
    end

    // Responder: idle-high line, turnaround zero, then data MSB first
    always_comb begin
        if (mon_cnt < 47)      mdi = 1'b1;
        else if (mon_cnt == 47) mdi = 1'b0;
        else if (mon_cnt < 64) mdi = rsp[63 - mon_cnt];
        else                   mdi = 1'b1;
    end

    // Table: maintenance word, PHY response, expected word afterwards
    localparam logic [31:0] VEC_WORD[4] = '{32'h5082_1234, 32'h6F86_0000, 32'h657E_FFFF, 32'h5AAA_A5C3};
    localparam logic [15:0] VEC_RSP [4] = '{16'h0000,      16'h796D,      16'h8001,      16'h0000};
    localparam logic [31:0] VEC_EXP [4] = '{32'h5082_1234, 32'h6F86_796D, 32'h657E_8001, 32'h5AAA_A5C3};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        mon_clr = 1'b0;
    endtask

    // Launch a frame; returns at the negedge right after the write edge
    task automatic launch(input logic [31:0] word, input logic [15:0] r);
        logic [31:0] st;
        rsp = r;
        clear_mon();
        wr(2'd3, word);
        rd(2'd2, st);
        chk("R3 idle low after launch", st, 32'h0);
    endtask

    // Count bus edges until idle returns
    task automatic wait_idle(output int n);
        logic [31:0] st;
        n = 0;
        while (n < 20000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            rd(2'd2, st);
            if (st[2]) break;
        end
    endtask

    task automatic check_frame(input string tag, input logic [31:0] word);
        int  mism;
        bit  is_rd;
        mism  = 0;
        is_rd = (word[29:28] == 2'b10);
        for (int k = 0; k < 64; k++) begin
            logic exp_o;
            logic exp_oe;
            exp_o  = (k < 32) ? 1'b1 : word[63 - k];
            exp_oe = !(is_rd && k >= 46);
            if (cap_oe[k] !== exp_oe) mism++;
            if (exp_oe && cap_o[k] !== exp_o) mism++;
        end
        chk({tag, " bit count"}, mon_cnt, 64);
        chk({tag, " bit mismatches"}, mism, 0);
    endtask

    initial begin
        logic [31:0] d;
        int n;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, d); chk("R1 status idle", d, 32'h0000_0004);
        rd(2'd0, d); chk("R1 control zero", d, 32'h0);
        rd(2'd1, d); chk("R1 config zero", d, 32'h0);
        rd(2'd3, d); chk("R1 maint zero", d, 32'h0);
        chk("R1 mdc low", {31'd0, mdc}, 32'h0);
        chk("R1 oe low", {31'd0, mdoe}, 32'h0);

        // R2: only the defined fields store and read back
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 control field", d, 32'h0000_0010);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 divisor field", d, 32'h001C_0000);
        wr(2'd1, 32'h0);          rd(2'd1, d); chk("R2 divisor clear", d, 32'h0);

        // Table walk at D=8: R3 timing, R4/R6 wire, R7 word, R10 release
        for (int v = 0; v < 4; v++) begin
            launch(VEC_WORD[v], VEC_RSP[v]);
            wait_idle(n);
            chk("R3 frame length 64*8", n, 512);
            check_frame("R4 R6 wire frame", VEC_WORD[v]);
            rd(2'd3, d); chk("R7 word after frame", d, VEC_EXP[v]);
            chk("R10 oe low when idle", {31'd0, mdoe}, 32'h0);
            chk("R5 mdc low when idle", {31'd0, mdc}, 32'h0);
        end

        // R5: divide by 48 (select 3)
        wr(2'd1, 32'h000C_0000);
        launch(32'h5082_1234, 16'h0);
        wait_idle(n);
        chk("R5 R3 frame length 64*48", n, 3072);
        chk("R5 period 48", rise_cyc[1] - rise_cyc[0], 48);
        chk("R5 high cycles 32*48", hi_cnt, 1536);
        check_frame("R4 wire at D48", 32'h5082_1234);

        // R5: divide by 64 (select 4), read frame
        wr(2'd1, 32'h0010_0000);
        launch(32'h6F86_0000, 16'hC3A5);
        wait_idle(n);
        chk("R5 R3 frame length 64*64", n, 4096);
        chk("R5 period 64", rise_cyc[1] - rise_cyc[0], 64);
        chk("R5 high cycles 32*64", hi_cnt, 2048);
        rd(2'd3, d); chk("R6 R7 read data at D64", d, 32'h6F86_C3A5);

        // R9: write during a running frame is ignored
        wr(2'd1, 32'h0);
        launch(32'h5AAA_A5C3, 16'h0);
        repeat (40) @(negedge clk);
        wr(2'd3, 32'h6F86_1111);
        rd(2'd3, d); chk("R9 word kept mid-frame", d, 32'h5AAA_A5C3);
        wait_idle(n);
        check_frame("R9 frame unaltered", 32'h5AAA_A5C3);
        rd(2'd3, d); chk("R9 word after frame", d, 32'h5AAA_A5C3);

        // R8: disabled port stores the word but emits nothing
        wr(2'd0, 32'h0);
        clear_mon();
        wr(2'd3, 32'h5082_0001);
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 100; c++) begin
                @(negedge clk);
                if (mdc || mdoe) seen++;
            end
            chk("R8 no MDC or drive while disabled", seen, 0);
        end
        chk("R8 no MDC edges", mon_cnt, 0);
        rd(2'd2, d); chk("R8 idle stays set", d, 32'h0000_0004);
        rd(2'd3, d); chk("R8 word stored", d, 32'h5082_0001);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule